// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Emulator

This block takes the device side of a single-wire humidity and temperature sensor link. It watches an open-drain data line and waits for a host to hold that line low for a long time as a start request. When it accepts a request, it takes a copy of its parallel data word. It waits briefly and then pulls the line low and releases it once as a presence handshake. After that it sends the word one bit at a time, starting with the most significant bit. Every bit starts with a low interval of fixed length. The length of the released interval that follows tells the host whether the bit is a zero or a one.

The block never drives the line high. Its only output to the line is a pull-low enable. The line level that comes back (host drive, device drive and pull-up combined) enters on the sense input. Each interval is a cycle count worked out at elaboration from a nanosecond parameter and the clock period, rounded up. A host on a different clock, or a model in a simulation, can therefore rely on fixed and known widths. A busy flag covers the whole reply, and a one-cycle done pulse marks the moment the line is released for the last time.

Top module: `hsens_emu`

## Requirements
- R1: While reset is asserted, and in the first cycle after an asynchronous reset that arrives in the middle of a reply, busy, done and line_pull_low are all 0.
- R2: A start request is accepted only if the synchronised line stayed low for at least ceil(START_MIN_NS/CLK_PERIOD_NS) cycles. A shorter low pulse leaves busy and line_pull_low at 0. One cycle below the limit is rejected, and exactly the limit is accepted.
- R3: line_pull_low first rises SYNC_STAGES+1+ceil(RESP_WAIT_NS/CLK_PERIOD_NS) cycles after the sense input returns high at the end of an accepted request.
- R4: The presence handshake is line_pull_low=1 for ceil(PRES_LOW_NS/CLK_PERIOD_NS) cycles and then 0 for ceil(PRES_HIGH_NS/CLK_PERIOD_NS) cycles.
- R5: WORD_BITS bits follow, most significant first. Each bit is line_pull_low=1 for ceil(BIT_LOW_NS/CLK_PERIOD_NS) cycles and then 0 for ceil(ZERO_HIGH_NS/CLK_PERIOD_NS) cycles for a 0 or ceil(ONE_HIGH_NS/CLK_PERIOD_NS) cycles for a 1.
- R6: After the last bit's high interval, line_pull_low=1 for ceil(END_LOW_NS/CLK_PERIOD_NS) cycles as an end marker. In the first cycle after that, done is 1 for exactly one cycle, with busy=0 and line_pull_low=0.
- R7: busy is 1 from the clock edge that accepts a request until the end marker completes. line_pull_low is never 1 while busy is 0.
- R8: The frame carries the value of tx_word sampled on the accepting edge, which is SYNC_STAGES+1 edges after the sense input rises. Changes to tx_word after that edge do not change the frame in progress.
- R9: Low pulses on the line from the host while busy is 1 are ignored. The frame timing is unchanged and no new frame starts after it.
- R10: Every interval is the rounded-up cycle count of its nanosecond parameter, including for clock periods that do not divide the interval exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | WORD_BITS | Word to send; sampled when a request is accepted |
| line_in | input | 1 | Sensed level of the open-drain line (1 = released) |
| line_pull_low | output | 1 | 1 pulls the line low, 0 releases it |
| busy | output | 1 | High from request acceptance until the end marker completes |
| done | output | 1 | One-cycle pulse when the end marker finishes |

## Verification
The collision of interest is between the edge that accepts a request and a change of tx_word on that same edge. The bench releases the host pulse and places a new word on tx_word just before edge SYNC_STAGES+1. Right after that edge it replaces the word with a different one. The decoded frame must equal the first word, and busy must already be 1 at that point. A second overlap is also exercised: the host pulls the line low for a long stretch in the middle of a frame, while the device is driving its own pulses. The bench judges this by exact pulse widths, by the decoded word, and by the absence of any second reply.

// File: rtl/hsens_emu_pkg.sv
`timescale 1ns/1ps
package hsens_emu_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_PRES_LO,
      ST_PRES_HI,
      ST_BIT_LO,
      ST_BIT_HI,
      ST_END_LO
   } emu_state_e;

   // Rounded-up conversion of a duration in ns to clock cycles.
   function automatic int unsigned cyc_ceil(input int unsigned ns,
                                            input int unsigned period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hsens_line_sync.sv
`timescale 1ns/1ps
module hsens_line_sync #(
   parameter int unsigned STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_s
);
   logic [STAGES-1:0] chain;

   // Released line reads high, so the chain resets to all ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_raw};
   end

   assign line_s = chain[STAGES-1];
endmodule

// File: rtl/hsens_start_detect.sv
`timescale 1ns/1ps
module hsens_start_detect #(
   parameter int unsigned MIN_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic line_s,
   output logic accept
);
   localparam int unsigned CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

   logic [CW-1:0] low_cnt;

   // Counts synchronised low cycles, saturating at the limit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_cnt <= '0;
      else if (!arm || line_s)    low_cnt <= '0;
      else if (low_cnt != LIMIT)  low_cnt <= low_cnt + 1'b1;
   end

   // First high cycle after a long enough low stretch.
   assign accept = arm && line_s && (low_cnt == LIMIT);
endmodule

// File: rtl/hsens_phase_timer.sv
`timescale 1ns/1ps
module hsens_phase_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/hsens_frame_shift.sv
`timescale 1ns/1ps
module hsens_frame_shift #(
   parameter int unsigned BITS = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [BITS-1:0] word,
   input  logic            advance,
   output logic            cur_bit,
   output logic            last_bit
);
   localparam int unsigned BW = $clog2(BITS + 1);

   logic [BITS-1:0] sr;
   logic [BW-1:0]   left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         left <= '0;
      end else if (load) begin
         sr   <= word;
         left <= BW'(BITS);
      end else if (advance) begin
         sr   <= sr << 1;
         left <= left - 1'b1;
      end
   end

   assign cur_bit  = sr[BITS-1];
   assign last_bit = (left == BW'(1));
endmodule

// File: rtl/hsens_emu.sv
`timescale 1ns/1ps
module hsens_emu #(
   parameter int unsigned CLK_PERIOD_NS = 84,
   parameter int unsigned WORD_BITS     = 40,
   parameter int unsigned SYNC_STAGES   = 3,
   parameter int unsigned START_MIN_NS  = 500_000,
   parameter int unsigned RESP_WAIT_NS  = 40_000,
   parameter int unsigned PRES_LOW_NS   = 80_000,
   parameter int unsigned PRES_HIGH_NS  = 80_000,
   parameter int unsigned BIT_LOW_NS    = 50_000,
   parameter int unsigned ZERO_HIGH_NS  = 24_000,
   parameter int unsigned ONE_HIGH_NS   = 68_000,
   parameter int unsigned END_LOW_NS    = 50_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WORD_BITS-1:0] tx_word,
   input  logic                 line_in,
   output logic                 line_pull_low,
   output logic                 busy,
   output logic                 done
);
   import hsens_emu_pkg::*;

   localparam int unsigned C_START = cyc_ceil(START_MIN_NS, CLK_PERIOD_NS);
   localparam int unsigned C_WAIT  = cyc_ceil(RESP_WAIT_NS, CLK_PERIOD_NS);
   localparam int unsigned C_PL    = cyc_ceil(PRES_LOW_NS,  CLK_PERIOD_NS);
   localparam int unsigned C_PH    = cyc_ceil(PRES_HIGH_NS, CLK_PERIOD_NS);
   localparam int unsigned C_BL    = cyc_ceil(BIT_LOW_NS,   CLK_PERIOD_NS);
   localparam int unsigned C_ZH    = cyc_ceil(ZERO_HIGH_NS, CLK_PERIOD_NS);
   localparam int unsigned C_OH    = cyc_ceil(ONE_HIGH_NS,  CLK_PERIOD_NS);
   localparam int unsigned C_EL    = cyc_ceil(END_LOW_NS,   CLK_PERIOD_NS);
   localparam int unsigned C_MAX   = umax(umax(umax(C_WAIT, C_PL), umax(C_PH, C_BL)),
                                          umax(umax(C_ZH, C_OH), C_EL));
   localparam int unsigned TW      = $clog2(C_MAX + 1);

   // Elaboration-time parameter checks
   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("hsens_emu: CLK_PERIOD_NS must be at least 1");
   end
   if (WORD_BITS < 1) begin : g_bad_width
      $error("hsens_emu: WORD_BITS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hsens_emu: SYNC_STAGES must be at least 2");
   end
   if (C_START < 1 || C_WAIT < 1 || C_PL < 1 || C_PH < 1 ||
       C_BL < 1 || C_ZH < 1 || C_EL < 1) begin : g_bad_interval
      $error("hsens_emu: every interval must be at least one cycle");
   end
   if (C_OH <= C_ZH) begin : g_bad_code
      $error("hsens_emu: a one must stay high longer than a zero");
   end

   emu_state_e     state, state_nxt;
   logic           line_s, accept, expired;
   logic           t_load;
   logic [TW-1:0]  t_val;
   logic           sh_load, sh_adv, cur_bit, last_bit;
   logic           done_nxt;

   hsens_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (line_in),
      .line_s   (line_s)
   );

   hsens_start_detect #(.MIN_CYC(C_START)) u_start (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (state == ST_IDLE),
      .line_s (line_s),
      .accept (accept)
   );

   hsens_phase_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (expired)
   );

   hsens_frame_shift #(.BITS(WORD_BITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .word     (tx_word),
      .advance  (sh_adv),
      .cur_bit  (cur_bit),
      .last_bit (last_bit)
   );

   // Each state lasts C cycles: the timer is loaded with C-1 on entry.
   always_comb begin
      state_nxt = state;
      t_load    = 1'b0;
      t_val     = '0;
      sh_load   = 1'b0;
      sh_adv    = 1'b0;
      done_nxt  = 1'b0;
      unique case (state)
         ST_IDLE: if (accept) begin
            state_nxt = ST_WAIT;
            t_load    = 1'b1;
            t_val     = TW'(C_WAIT - 1);
            sh_load   = 1'b1;
         end
         ST_WAIT: if (expired) begin
            state_nxt = ST_PRES_LO;
            t_load    = 1'b1;
            t_val     = TW'(C_PL - 1);
         end
         ST_PRES_LO: if (expired) begin
            state_nxt = ST_PRES_HI;
            t_load    = 1'b1;
            t_val     = TW'(C_PH - 1);
         end
         ST_PRES_HI: if (expired) begin
            state_nxt = ST_BIT_LO;
            t_load    = 1'b1;
            t_val     = TW'(C_BL - 1);
         end
         ST_BIT_LO: if (expired) begin
            state_nxt = ST_BIT_HI;
            t_load    = 1'b1;
            t_val     = cur_bit ? TW'(C_OH - 1) : TW'(C_ZH - 1);
         end
         ST_BIT_HI: if (expired) begin
            t_load = 1'b1;
            if (last_bit) begin
               state_nxt = ST_END_LO;
               t_val     = TW'(C_EL - 1);
            end else begin
               state_nxt = ST_BIT_LO;
               t_val     = TW'(C_BL - 1);
               sh_adv    = 1'b1;
            end
         end
         ST_END_LO: if (expired) begin
            state_nxt = ST_IDLE;
            done_nxt  = 1'b1;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nxt;
         done  <= done_nxt;
      end
   end

   assign line_pull_low = (state == ST_PRES_LO) || (state == ST_BIT_LO) ||
                          (state == ST_END_LO);
   assign busy          = (state != ST_IDLE);
endmodule

// File: rtl/hsens_emu_chk.sv
`timescale 1ns/1ps
module hsens_emu_chk #(
   parameter int unsigned CLK_PERIOD_NS = 84,
   parameter int unsigned PRES_LOW_NS   = 80_000,
   parameter int unsigned BIT_LOW_NS    = 50_000,
   parameter int unsigned END_LOW_NS    = 50_000
) (
   input logic clk,
   input logic rst_n,
   input logic line_pull_low,
   input logic busy,
   input logic done
);
   import hsens_emu_pkg::*;

   localparam int unsigned MAX_LOW = umax(umax(cyc_ceil(PRES_LOW_NS, CLK_PERIOD_NS),
                                               cyc_ceil(BIT_LOW_NS, CLK_PERIOD_NS)),
                                          cyc_ceil(END_LOW_NS, CLK_PERIOD_NS));

   int unsigned low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             low_run <= 0;
      else if (line_pull_low) low_run <= low_run + 1;
      else                    low_run <= 0;
   end

   assert_drive_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      line_pull_low |-> busy);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !line_pull_low));

   assert_busy_ends_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_accept_starts_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line_pull_low);

   assert_low_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= MAX_LOW);
endmodule

bind hsens_emu hsens_emu_chk #(
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .PRES_LOW_NS   (PRES_LOW_NS),
   .BIT_LOW_NS    (BIT_LOW_NS),
   .END_LOW_NS    (END_LOW_NS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .line_pull_low (line_pull_low),
   .busy          (busy),
   .done          (done)
);

// File: tb/hsens_emu_test.sv
`timescale 1ns/1ps
module hsens_emu_test;
   localparam int PERIOD = 700;   // claimed period: exercises rounding up
   localparam int SYNC   = 3;
   localparam int WB     = 40;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   localparam int E_START = cdiv(500_000, PERIOD);
   localparam int E_WAIT  = cdiv(40_000, PERIOD);
   localparam int E_PL    = cdiv(80_000, PERIOD);
   localparam int E_PH    = cdiv(80_000, PERIOD);
   localparam int E_BL    = cdiv(50_000, PERIOD);
   localparam int E_ZH    = cdiv(24_000, PERIOD);
   localparam int E_OH    = cdiv(68_000, PERIOD);
   localparam int E_EL    = cdiv(50_000, PERIOD);
   localparam int E_LAT   = SYNC + 1 + E_WAIT;

   // Vector table: host low length, word, whether a reply is expected
   localparam int NV = 5;
   localparam int       V_LEN [NV] = '{cdiv(1_000_000, PERIOD), 400, E_START, E_START - 1, 1000};
   localparam logic [WB-1:0] V_WORD [NV] = '{40'hA50F3C817E, 40'h123456789A, 40'hFFFFFFFFFF,
                                             40'h0000000000, 40'h8000000001};
   localparam bit       V_ACC [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [WB-1:0] tx_word = '0;
   logic          host_low = 1'b0;
   logic          line_in;
   logic          line_pull_low, busy, done;
   int            n_chk = 0;
   int            n_fail = 0;

   always #2 clk = ~clk;

   assign line_in = !(host_low || line_pull_low);

   hsens_emu #(.CLK_PERIOD_NS(PERIOD), .WORD_BITS(WB), .SYNC_STAGES(SYNC)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_word       (tx_word),
      .line_in       (line_in),
      .line_pull_low (line_pull_low),
      .busy          (busy),
      .done          (done)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_pulse(input int len);
      @(negedge clk);
      host_low = 1'b1;
      repeat (len) @(negedge clk);
      host_low = 1'b0;
   endtask

   task automatic get_run(input logic lvl, output int n);
      n = 0;
      while (line_pull_low == lvl && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // Called at a negedge that is 'start_n' negedges after the host release.
   task automatic capture(input logic [WB-1:0] exp_word, input int start_n);
      int n, h;
      bit bad;
      logic [WB-1:0] got;
      n = start_n;
      got = '0;
      bad = 1'b0;
      do begin
         @(negedge clk);
         n++;
      end while (!line_pull_low && n < 100000);
      chk(n == E_LAT, "R3 response latency", n, E_LAT);
      chk(busy, "R7 busy during reply", busy, 1);
      get_run(1'b1, n);
      chk(n == E_PL, "R4/R10 presence low", n, E_PL);
      get_run(1'b0, n);
      chk(n == E_PH, "R4/R10 presence high", n, E_PH);
      for (int i = 0; i < WB; i++) begin
         get_run(1'b1, n);
         if (n != E_BL) bad = 1'b1;
         get_run(1'b0, h);
         if (h != E_ZH && h != E_OH) bad = 1'b1;
         got = {got[WB-2:0], (h == E_OH)};
      end
      chk(!bad, "R5/R10 bit pulse widths", bad, 0);
      chk(got == exp_word, "R5/R8 decoded word", got, exp_word);
      get_run(1'b1, n);
      chk(n == E_EL, "R6 end marker", n, E_EL);
      chk(done && !busy && !line_pull_low, "R6 done at release",
          {done, busy, line_pull_low}, 3'b100);
      @(negedge clk);
      chk(!done, "R6 done one cycle", done, 0);
   endtask

   task automatic quiet(input int cyc, input string req);
      bit seen;
      seen = 1'b0;
      repeat (cyc) begin
         @(negedge clk);
         if (busy || line_pull_low) seen = 1'b1;
      end
      chk(!seen, req, seen, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(!busy && !done && !line_pull_low, "R1 reset state",
          {busy, done, line_pull_low}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // Table walk: R2 acceptance boundary and R5 data patterns
      for (int v = 0; v < NV; v++) begin
         tx_word = V_WORD[v];
         host_pulse(V_LEN[v]);
         if (V_ACC[v]) capture(V_WORD[v], 0);
         else          quiet(200, "R2 short pulse ignored");
         repeat (20) @(negedge clk);
      end

      // R8: word change on the accepting edge and right after it
      tx_word = 40'h1111111111;
      host_pulse(cdiv(1_000_000, PERIOD));
      repeat (SYNC) @(negedge clk);
      tx_word = 40'hC3A55A3CF0;
      @(negedge clk);
      tx_word = 40'h0F0F0F0F0F;
      chk(busy, "R7 busy from accepting edge", busy, 1);
      capture(40'hC3A55A3CF0, SYNC + 1);
      repeat (20) @(negedge clk);

      // R9: host pulls low in the middle of a frame
      tx_word = 40'h5A5A5A5A5A;
      host_pulse(cdiv(1_000_000, PERIOD));
      fork
         capture(40'h5A5A5A5A5A, 0);
         begin
            repeat (400) @(negedge clk);
            host_low = 1'b1;
            repeat (E_START + 100) @(negedge clk);
            host_low = 1'b0;
         end
      join
      quiet(300, "R9 no restart after frame");

      // R1: reset in the middle of a frame, then a clean frame
      tx_word = 40'h00FF00FF00;
      host_pulse(cdiv(1_000_000, PERIOD));
      repeat (500) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !done && !line_pull_low, "R1 mid-frame reset",
          {busy, done, line_pull_low}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      host_pulse(cdiv(1_000_000, PERIOD));
      capture(40'h00FF00FF00, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule